// File: doc/BRIEF.md
# Debug Watchpoint Comparator Unit

This block observes three processor buses and raises watchpoint matches and breakpoint requests. The buses are the instruction fetch address, the load/store address and the load/store data. It has eight comparators with a fixed assignment:

- Comparators 0 to 3 look at instruction fetch addresses.
- Comparators 4 and 5 look at load/store addresses.
- Comparators 6 and 7 look at load/store data.

Each comparator holds a 32-bit reference value and a two-bit relational condition. It reports its own match bit. Each comparator can also be allowed to drive a shared internal breakpoint request.

Software programs the comparators through a simple write-only register port. Each comparator has two words: its reference value and its control word. The match bits and the breakpoint request are registered. They describe the bus cycle presented one clock earlier.

Top module: `dbg_watch_unit`

## Requirements
- R1: After reset, `wp_match` and `brk_req` are 0 and every comparator is disabled, with reference value 0 and condition EQ.
- R2: Comparators 0..3 compare `if_addr`, comparators 4..5 compare `ls_addr`, and comparators 6..7 compare `ls_data`. Comparator i drives `wp_match[i]`.
- R3: The condition code is 0 = bus equals value, 1 = bus differs from value, 2 = bus less than value, 3 = bus greater than value. All comparisons are unsigned 32-bit.
- R4: Instruction comparators can match only in a cycle with `if_vld` high. Data comparators can match only in a cycle with `ls_vld` high.
- R5: `wp_match` reflects the bus cycle sampled at the previous rising clock edge and holds for exactly that one cycle.
- R6: A comparator whose enable bit is 0 never matches, whatever its condition, the NE condition included.
- R7: `brk_req` is high one cycle after a bus cycle in which at least one comparator matches with its break-enable bit set. Matches without break enable leave `brk_req` low.
- R8: A write with `cfg_we` high uses `cfg_addr` = {comparator index, select}. Select 0 writes the 32-bit reference value. Select 1 writes the control word: bits [1:0] condition, bit 2 enable, bit 3 break enable. A write takes effect for bus cycles from the next clock on. A bus cycle in the same clock as the write uses the old setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | {comparator index[3:1], select[0]} |
| cfg_wdata | input | 32 | Configuration write data |
| if_vld | input | 1 | Instruction fetch valid |
| if_addr | input | 32 | Instruction fetch address |
| ls_vld | input | 1 | Load/store valid |
| ls_addr | input | 32 | Load/store address |
| ls_data | input | 32 | Load/store data |
| wp_match | output | 8 | Per-comparator registered match |
| brk_req | output | 1 | Registered internal breakpoint request |

## Verification
The directed tests place bus values one below, equal to and one above each reference value, and also at 0 and 0xFFFFFFFF. These cases tell the EQ, NE, LT and GT conditions apart, and they expose any signed comparison or off-by-one boundary. The same addresses are also driven with valid low, with the comparator disabled under NE, and with a configuration write in the same cycle as a matching bus cycle. These runs separate qualification, enable and write timing. A long pseudo-random phase then mixes writes to every comparator with traffic on all three buses. A behavioural model is compared against the design on every clock, which catches crossed bus assignments and break-enable masking errors.

// File: rtl/dbg_watch_pkg.sv
package dbg_watch_pkg;
  typedef enum logic [1:0] {
    CMP_EQ = 2'd0,
    CMP_NE = 2'd1,
    CMP_LT = 2'd2,
    CMP_GT = 2'd3
  } cmp_cond_e;

  // control word layout: [3] break enable, [2] enable, [1:0] condition
  typedef struct packed {
    logic      brk_en;
    logic      en;
    cmp_cond_e cond;
  } wp_ctl_t;

  localparam int unsigned CTL_W = $bits(wp_ctl_t);
endpackage

// File: rtl/wp_cfg_regs.sv
module wp_cfg_regs
  import dbg_watch_pkg::*;
#(
  parameter int unsigned N_CMP  = 8,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned IDX_W = (N_CMP > 1) ? $clog2(N_CMP) : 1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [IDX_W-1:0]              wr_idx,
  input  logic                          wr_sel,
  input  logic [DATA_W-1:0]             wr_data,
  output logic [N_CMP-1:0][DATA_W-1:0]  ref_val,
  output wp_ctl_t [N_CMP-1:0]           ref_ctl
);

  for (genvar g = 0; g < N_CMP; g++) begin : g_entry
    logic              hit_entry;
    logic              val_ld, ctl_ld;
    logic [DATA_W-1:0] val_d, val_q;
    wp_ctl_t           ctl_d, ctl_q;

    always_comb begin
      hit_entry = wr_en && (wr_idx == IDX_W'(g));
      val_ld    = hit_entry && !wr_sel;
      ctl_ld    = hit_entry &&  wr_sel;
      val_d     = val_ld ? wr_data : val_q;
      ctl_d     = ctl_ld ? wp_ctl_t'(wr_data[CTL_W-1:0]) : ctl_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        val_q <= '0;
        ctl_q <= '0;
      end else begin
        val_q <= val_d;
        ctl_q <= ctl_d;
      end
    end

    assign ref_val[g] = val_q;
    assign ref_ctl[g] = ctl_q;

    // R8
    ctl_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel && wr_idx == IDX_W'(g)) |=> (ctl_q == $past(wr_data[CTL_W-1:0])));
    // R8
    val_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_sel && wr_idx == IDX_W'(g)) |=> (val_q == $past(wr_data)));
  end

endmodule

// File: rtl/wp_compare.sv
module wp_compare
  import dbg_watch_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              qual,
  input  logic [DATA_W-1:0] operand,
  input  logic [DATA_W-1:0] ref_val,
  input  wp_ctl_t           ctl,
  output logic              hit_q,
  output logic              brk_q
);

  logic rel;
  logic hit_d, brk_d;

  always_comb begin
    unique case (ctl.cond)
      CMP_EQ:  rel = (operand == ref_val);
      CMP_NE:  rel = (operand != ref_val);
      CMP_LT:  rel = (operand <  ref_val);
      CMP_GT:  rel = (operand >  ref_val);
      default: rel = 1'b0;
    endcase
    hit_d = qual && ctl.en && rel;
    brk_d = hit_d && ctl.brk_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_q <= 1'b0;
      brk_q <= 1'b0;
    end else begin
      hit_q <= hit_d;
      brk_q <= brk_d;
    end
  end

  // R6
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_q |-> $past(ctl.en));
  // R3
  eq_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_q && $past(ctl.cond) == CMP_EQ) |-> ($past(operand) == $past(ref_val)));
  // R3
  lt_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_q && $past(ctl.cond) == CMP_LT) |-> ($past(operand) < $past(ref_val)));

endmodule

// File: rtl/dbg_watch_unit.sv
module dbg_watch_unit
  import dbg_watch_pkg::*;
#(
  parameter int unsigned N_IA   = 4,
  parameter int unsigned N_DA   = 2,
  parameter int unsigned N_DV   = 2,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned N_CMP = N_IA + N_DA + N_DV,
  localparam int unsigned IDX_W = (N_CMP > 1) ? $clog2(N_CMP) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [IDX_W:0]    cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  logic              if_vld,
  input  logic [DATA_W-1:0] if_addr,
  input  logic              ls_vld,
  input  logic [DATA_W-1:0] ls_addr,
  input  logic [DATA_W-1:0] ls_data,
  output logic [N_CMP-1:0]  wp_match,
  output logic              brk_req
);

  logic [N_CMP-1:0][DATA_W-1:0] ref_val;
  wp_ctl_t [N_CMP-1:0]          ref_ctl;
  logic [N_CMP-1:0]             brk_vec;

  wp_cfg_regs #(.N_CMP(N_CMP), .DATA_W(DATA_W)) u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cfg_we),
    .wr_idx  (cfg_addr[IDX_W:1]),
    .wr_sel  (cfg_addr[0]),
    .wr_data (cfg_wdata),
    .ref_val (ref_val),
    .ref_ctl (ref_ctl)
  );

  for (genvar g = 0; g < N_CMP; g++) begin : g_cmp
    logic              qual;
    logic [DATA_W-1:0] operand;

    if (g < N_IA) begin : g_ia
      assign qual    = if_vld;
      assign operand = if_addr;
    end else if (g < N_IA + N_DA) begin : g_da
      assign qual    = ls_vld;
      assign operand = ls_addr;
    end else begin : g_dv
      assign qual    = ls_vld;
      assign operand = ls_data;
    end

    wp_compare #(.DATA_W(DATA_W)) u_cmp (
      .clk     (clk),
      .rst_n   (rst_n),
      .qual    (qual),
      .operand (operand),
      .ref_val (ref_val[g]),
      .ctl     (ref_ctl[g]),
      .hit_q   (wp_match[g]),
      .brk_q   (brk_vec[g])
    );
  end

  assign brk_req = |brk_vec;

  // R4
  ifetch_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|wp_match[N_IA-1:0]) |-> $past(if_vld));
  // R4
  ldst_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|wp_match[N_CMP-1:N_IA]) |-> $past(ls_vld));
  // R7
  brk_needs_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    brk_req |-> (|wp_match));

endmodule

// File: tb/dbg_watch_unit_tb.sv
`timescale 1ns/1ps
module dbg_watch_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        if_vld = 1'b0, ls_vld = 1'b0;
  logic [31:0] if_addr = '0, ls_addr = '0, ls_data = '0;
  logic [7:0]  wp_match;
  logic        brk_req;

  int total = 0, bad = 0;
  string phase = "R1";
  bit finished = 0;

  dbg_watch_unit u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .if_vld(if_vld), .if_addr(if_addr),
    .ls_vld(ls_vld), .ls_addr(ls_addr), .ls_data(ls_data),
    .wp_match(wp_match), .brk_req(brk_req)
  );

  always #2.5 clk = ~clk;

  // behavioural reference model
  logic [31:0] m_val [8];
  logic [3:0]  m_ctl [8];
  logic [7:0]  exp_match;
  logic        exp_brk;

  function automatic bit rel(input logic [1:0] c, input logic [31:0] a, input logic [31:0] v);
    case (c)
      2'd0: return a == v;
      2'd1: return a != v;
      2'd2: return a < v;
      default: return a > v;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) begin m_val[i] = '0; m_ctl[i] = '0; end
      exp_match = '0; exp_brk = 1'b0;
    end else begin
      exp_brk = 1'b0;
      for (int i = 0; i < 8; i++) begin
        logic q; logic [31:0] op;
        if (i < 4)      begin q = if_vld; op = if_addr; end
        else if (i < 6) begin q = ls_vld; op = ls_addr; end
        else            begin q = ls_vld; op = ls_data; end
        exp_match[i] = q && m_ctl[i][2] && rel(m_ctl[i][1:0], op, m_val[i]);
        if (exp_match[i] && m_ctl[i][3]) exp_brk = 1'b1;
      end
      if (cfg_we) begin
        if (cfg_addr[0]) m_ctl[cfg_addr[3:1]] = cfg_wdata[3:0];
        else             m_val[cfg_addr[3:1]] = cfg_wdata;
      end
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // every-cycle comparison, sampled on the falling edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk(phase, "wp_match", {24'd0, wp_match}, {24'd0, exp_match});
      chk(phase, "brk_req", {31'd0, brk_req}, {31'd0, exp_brk});
    end
  end

  task automatic wr(input int idx, input bit sel, input logic [31:0] d);
    cfg_we = 1'b1; cfg_addr = {idx[2:0], sel}; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic bus(input bit iv, input logic [31:0] ia, input bit lv,
                     input logic [31:0] la, input logic [31:0] ld);
    if_vld = iv; if_addr = ia; ls_vld = lv; ls_addr = la; ls_data = ld;
    @(negedge clk);
  endtask

  function automatic logic [31:0] pick(input logic [31:0] r);
    case (r[2:0])
      3'd0: return 32'h0;
      3'd1: return 32'h0000_00FF;
      3'd2: return 32'h0000_0100;
      3'd3: return 32'h0000_0101;
      3'd4: return 32'h0000_0200;
      3'd5: return 32'hFFFF_FFFF;
      3'd6: return 32'h8000_0000;
      default: return r;
    endcase
  endfunction

  initial begin : watchdog
    #(5ns * 100000);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : stim
    logic [31:0] seed;
    seed = 32'h1234_5678;
    #1;
    // R1: outputs during reset
    chk("R1", "reset wp_match", {24'd0, wp_match}, 32'd0);
    chk("R1", "reset brk_req", {31'd0, brk_req}, 32'd0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: all disabled after reset, bus active with zero values
    phase = "R1";
    bus(1, 0, 1, 0, 0);
    bus(1, 32'h100, 1, 32'h100, 32'h100);
    // R8 / R2: program comparators and check same-cycle write uses old setting
    phase = "R8";
    wr(0, 0, 32'h100);
    if_vld = 1; if_addr = 32'h100;
    wr(0, 1, 32'h4);            // enable EQ while fetch of 0x100 is present
    bus(1, 32'h100, 0, 0, 0);   // now matches
    phase = "R2";
    wr(4, 0, 32'h200); wr(4, 1, 32'h4);
    wr(6, 0, 32'hCAFE_0000); wr(6, 1, 32'h4);
    bus(1, 32'h200, 1, 32'h100, 32'h200);
    bus(0, 0, 1, 32'h200, 32'hCAFE_0000);
    bus(1, 32'hCAFE_0000, 1, 32'hCAFE_0000, 32'h200);
    // R3: relational conditions and unsigned boundaries
    phase = "R3";
    wr(1, 0, 32'h100); wr(1, 1, 32'h5);   // NE
    wr(2, 0, 32'h100); wr(2, 1, 32'h6);   // LT
    wr(3, 0, 32'h100); wr(3, 1, 32'h7);   // GT
    wr(5, 0, 32'h8000_0000); wr(5, 1, 32'h7); // GT on data address
    wr(7, 0, 32'h1); wr(7, 1, 32'h6);     // LT on data value
    bus(1, 32'hFF, 1, 32'h7FFF_FFFF, 32'h0);
    bus(1, 32'h100, 1, 32'h8000_0000, 32'h1);
    bus(1, 32'h101, 1, 32'h8000_0001, 32'hFFFF_FFFF);
    bus(1, 32'hFFFF_FFFF, 1, 32'hFFFF_FFFF, 32'h0);
    bus(1, 32'h0, 1, 32'h0, 32'h8000_0000);
    // R4: valid low blocks everything
    phase = "R4";
    bus(0, 32'h100, 0, 32'h200, 32'hCAFE_0000);
    bus(0, 32'h0, 1, 32'h200, 32'h0);
    bus(1, 32'h100, 0, 32'hFFFF_FFFF, 32'h0);
    // R5: single-cycle pulse
    phase = "R5";
    bus(1, 32'h100, 0, 0, 0);
    bus(0, 32'h100, 0, 0, 0);
    bus(0, 0, 0, 0, 0);
    // R6: disabled NE never matches
    phase = "R6";
    wr(1, 1, 32'h1);
    wr(0, 1, 32'h0);
    bus(1, 32'h5555, 1, 0, 0);
    bus(1, 32'h100, 0, 0, 0);
    // R7: break enables
    phase = "R7";
    wr(0, 1, 32'h4);          // match without break
    bus(1, 32'h100, 0, 0, 0);
    wr(0, 1, 32'hC);          // with break
    bus(1, 32'h100, 0, 0, 0);
    wr(6, 1, 32'hC);
    bus(0, 0, 1, 0, 32'hCAFE_0000);
    bus(0, 0, 0, 0, 32'hCAFE_0000);
    // R2/R3/R8 mixed pseudo-random phase
    phase = "R2";
    for (int n = 0; n < 600; n++) begin
      seed = seed * 32'd1103515245 + 32'd12345;
      if (seed[31:30] == 2'b00) begin
        cfg_we = 1'b1;
        cfg_addr = seed[27:24];
        cfg_wdata = cfg_addr[0] ? {28'd0, seed[19:16]} : pick(seed ^ (seed >> 7));
      end else cfg_we = 1'b0;
      if_vld = seed[29]; ls_vld = seed[28];
      if_addr = pick(seed >> 3); ls_addr = pick(seed >> 6); ls_data = pick(seed >> 9);
      @(negedge clk);
    end
    cfg_we = 1'b0;
    bus(0, 0, 0, 0, 0);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule